// File: doc/BRIEF.md
# Dual-Core Peripheral Interrupt Router

This block sits between a bank of peripheral interrupt lines and the interrupt controllers of two processor cores. Each source line has its own small routing register holding a two-bit enable field, one bit per core. A source can be sent to core 0, to core 1, to both at once, or to neither. Each core receives its own vector of interrupt lines. The gating is purely combinational, so level and edge behaviour pass through unchanged.

Software programs the routing through a halfword register port. The routing registers are packed halfwords starting at byte offset 0x80. A separate register at byte offset 0x4 returns the number of the core making the access. Software uses that number to build the one-hot enable value for its own core. Routing can be saved by reading every register and restored exactly by writing the values back. Prioritisation, masking and acknowledgement are handled by the downstream per-core controllers.

Top module: `irq_steer`

## Requirements
- R1: After reset every routing register reads 0, both core output vectors are all zero whatever the source lines do, and the read data is 0.
- R2: Bit 0 of the routing register for source n enables delivery: core 0 line n equals source line n when the bit is 1, and 0 otherwise.
- R3: Bit 1 of the routing register for source n enables delivery: core 1 line n equals source line n when the bit is 1, and 0 otherwise.
- R4: Value 3 (both bits set) delivers source n to both cores at once. Writing 0 disconnects source n from both cores.
- R5: The routing register for source n (0 to NUM_SRC-1) sits at byte address 0x80 + 2*n. A read of it returns the enable field last written, in bits 1:0.
- R6: Bits 15:2 of every routing register read as zero, and writing ones to them changes neither the readback nor the routing.
- R7: A read of byte address 0x4 returns the requester ID input (0 or 1) zero-extended to 16 bits.
- R8: Writes to byte address 0x4 are ignored. All routing is left unchanged, and the register still returns the requester ID.
- R9: Accesses to any other address read 0 and writes to them have no effect. This covers odd addresses, addresses below 0x80 other than 0x4, and addresses at or above 0x80 + 2*NUM_SRC.
- R10: Read data appears in the cycle after the read request is sampled. In any cycle after a cycle without a read, the read data is 0.
- R11: The core outputs follow the source lines combinationally, with no clock edge in between.
- R12: If software reads every routing register, clears them all, then writes the saved values back, the routing and the readbacks match the original state exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (9) | Byte address of the halfword |
| bus_wdata | input | 16 | Write data |
| bus_req_id | input | 1 | Number of the core making the access |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| src_irq | input | NUM_SRC (112) | Peripheral interrupt lines |
| core0_irq | output | NUM_SRC (112) | Interrupt lines delivered to core 0 |
| core1_irq | output | NUM_SRC (112) | Interrupt lines delivered to core 1 |

## Verification
The bench walks every source through all four enable values and writes ones into the reserved bits each time. This exposes an off-by-one in the halfword index, which would steer a neighbouring line, and it exposes swapped core bits, which would deliver an interrupt to the wrong core. It also catches reserved bits that are stored or leak into the enable field, which would make the readback differ from the routed state.

Writes to the core-ID register and to holes just outside the routing window are probed: 0x7E, the odd byte 0x81, and 0x160. A design with a loose decoder would corrupt routing there, which shows up on the outputs and in full readbacks. A save, clear and restore pass confirms that the readback fully describes the routing. Random source patterns are checked without a clock edge, which would reveal any register on the output path.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NUM_CORES = 2;

  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_CPUID = 2'd1,
    DK_ROUTE = 2'd2
  } dec_kind_e;
endpackage

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int NUM_SRC    = 112,
  parameter int IDX_W      = 7,
  parameter int ROUTE_BASE = 'h80,
  parameter int ID_OFFSET  = 'h4
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ROUTE_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(2 * NUM_SRC);
  localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_OFFSET);

  logic [ADDR_W-1:0] off;
  logic              in_win;

  always_comb begin
    off    = addr - BASE_A;
    in_win = (addr >= BASE_A) && (off < SPAN_A) && !off[0];
    idx    = off[IDX_W:1];
    if (in_win)
      kind = DK_ROUTE;
    else if (addr == ID_A)
      kind = DK_CPUID;
    else
      kind = DK_NONE;
  end
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 112,
  parameter int IDX_W   = 7,
  parameter int DATA_W  = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  dec_kind_e                             kind,
  input  logic [IDX_W-1:0]                      idx,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [NUM_SRC-1:0][NUM_CORES-1:0]     route_q
);
  logic                 wr_hit;
  logic [NUM_SRC-1:0]   load;
  logic [NUM_CORES-1:0] new_en;

  // next-state: one-hot load strobe and the enable field to store
  always_comb begin
    wr_hit = wr_en && (kind == DK_ROUTE);
    load   = '0;
    if (wr_hit)
      load[idx] = 1'b1;
    new_en = wdata[NUM_CORES-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_q[i] <= '0;
      else if (load[i])
        route_q[i] <= new_en;
    end
  end

  // R5: a routed write lands in the addressed register
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> route_q[$past(idx)] == $past(wdata[NUM_CORES-1:0]));

  // R6: reserved bits in the write data never change what is stored
  assert_rsvd_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (|wdata[DATA_W-1:NUM_CORES])) |=>
      route_q[$past(idx)] == $past(wdata[NUM_CORES-1:0]));

  // R9: without a routed write the register array holds
  assert_array_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(route_q));
endmodule

// File: rtl/irq_steer_rdport.sv
module irq_steer_rdport
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 112,
  parameter int IDX_W   = 7,
  parameter int DATA_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sel,
  input  logic                              we,
  input  dec_kind_e                         kind,
  input  logic [IDX_W-1:0]                  idx,
  input  logic                              req_id,
  input  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_q,
  output logic [DATA_W-1:0]                 rdata
);
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_d;
  logic              rd_en;

  always_comb begin
    case (kind)
      DK_ROUTE: rd_val = DATA_W'(route_q[idx]);
      DK_CPUID: rd_val = DATA_W'(req_id);
      default:  rd_val = '0;
    endcase
    rd_en   = sel && !we;
    rdata_d = rd_en ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else
      rdata <= rdata_d;
  end

  // R7: core-ID read returns the requester number
  assert_cpuid_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && kind == DK_CPUID) |=> rdata == DATA_W'($past(req_id)));

  // R10: no read request means zero read data next cycle
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> rdata == '0);

  // R9: unmapped reads return zero
  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && kind == DK_NONE) |=> rdata == '0);
endmodule

// File: rtl/irq_steer_gate.sv
module irq_steer_gate
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 112
) (
  input  logic [NUM_SRC-1:0]                src_irq,
  input  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_q,
  output logic [NUM_CORES-1:0][NUM_SRC-1:0] core_irq
);
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_line
      assign core_irq[k][n] = src_irq[n] & route_q[n][k];
    end
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC    = 112,
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 16,
  parameter int ROUTE_BASE = 'h80,
  parameter int ID_OFFSET  = 'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_req_id,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_irq,
  output logic [NUM_SRC-1:0] core0_irq,
  output logic [NUM_SRC-1:0] core1_irq
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [1:0]                        rst_pipe;
  logic                              rst_sync_n;
  dec_kind_e                         kind;
  logic [IDX_W-1:0]                  idx;
  logic                              wr_en;
  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_q;
  logic [NUM_CORES-1:0][NUM_SRC-1:0] core_irq;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];
  assign wr_en      = bus_sel && bus_we;

  irq_steer_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W),
    .ROUTE_BASE(ROUTE_BASE), .ID_OFFSET(ID_OFFSET)
  ) u_decode (
    .addr(bus_addr), .kind(kind), .idx(idx)
  );

  irq_steer_regs #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .kind(kind),
    .idx(idx), .wdata(bus_wdata), .route_q(route_q)
  );

  irq_steer_rdport #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_rdport (
    .clk(clk), .rst_n(rst_sync_n), .sel(bus_sel), .we(bus_we),
    .kind(kind), .idx(idx), .req_id(bus_req_id),
    .route_q(route_q), .rdata(bus_rdata)
  );

  irq_steer_gate #(
    .NUM_SRC(NUM_SRC)
  ) u_gate (
    .src_irq(src_irq), .route_q(route_q), .core_irq(core_irq)
  );

  assign core0_irq = core_irq[0];
  assign core1_irq = core_irq[1];

  // R2: core 0 never sees a line that is not raised at the source
  assert_core0_subset_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (core0_irq & ~src_irq) == '0);

  // R3: core 1 never sees a line that is not raised at the source
  assert_core1_subset_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (core1_irq & ~src_irq) == '0);
endmodule

// File: tb/test_irq_steer.sv
`timescale 1ns/1ps
module test_irq_steer;
  localparam int NS = 112;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we, bus_req_id;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata, bus_rdata;
  logic [NS-1:0] src_irq, core0_irq, core1_irq;

  logic [NS-1:0] m0, m1;
  logic [15:0]   saved [NS];
  int            nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  irq_steer i_irq_steer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_req_id(bus_req_id),
    .bus_rdata(bus_rdata), .src_irq(src_irq),
    .core0_irq(core0_irq), .core1_irq(core1_irq)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    #1;
    chk({tag, " core0"}, core0_irq, src_irq & m0);
    chk({tag, " core1"}, core1_irq, src_irq & m1);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1;
    bus_addr = AW'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic id, output logic [15:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0;
    bus_addr = AW'(a); bus_req_id = id;
    @(negedge clk);
    q = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_all_regs(input string tag);
    logic [15:0] q;
    for (int n = 0; n < NS; n++) begin
      rd('h80 + 2 * n, 1'b0, q);
      chk(tag, q, {14'd0, m1[n], m0[n]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] q;
    int holes [6];
    holes = '{'h0, 'h2, 'h7E, 'h81, 'h160, 'h1FE};
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; bus_req_id = 0;
    src_irq = '1; m0 = '0; m1 = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    chk("R1 rdata", bus_rdata, 16'd0);
    chk_out("R1 outputs");
    check_all_regs("R1 readback");

    // R2 R3 R4 R5 R6: every source through every enable value
    for (int n = 0; n < NS; n++) begin
      for (int v = 0; v < 4; v++) begin
        wr('h80 + 2 * n, 'hFFFC | v);
        m0[n] = v[0]; m1[n] = v[1];
        rd('h80 + 2 * n, 1'b1, q);
        chk("R5 R6 readback", q, 16'(v));
        src_irq = '0; src_irq[n] = 1'b1;
        chk_out(v == 3 ? "R4 both" : (v == 0 ? "R4 none" : "R2 R3 single"));
        src_irq = '1;
        chk_out("R2 R3 all-high");
      end
      wr('h80 + 2 * n, (n * 7 + 1) % 4);
      m0[n] = ((n * 7 + 1) % 4) & 1; m1[n] = (((n * 7 + 1) % 4) >> 1) & 1;
    end
    check_all_regs("R5 mixed readback");

    // R11: outputs follow random sources without a clock edge
    for (int p = 0; p < 20; p++) begin
      @(negedge clk);
      #1 src_irq = NS'({$urandom, $urandom, $urandom, $urandom});
      chk_out("R11 combinational");
    end

    // R4: disconnect by writing zero
    wr('h80 + 2 * 5, 0); m0[5] = 0; m1[5] = 0;
    src_irq = '1;
    chk_out("R4 disconnect");

    // R7: requester ID
    rd('h4, 1'b0, q); chk("R7 id0", q, 16'd0);
    rd('h4, 1'b1, q); chk("R7 id1", q, 16'd1);

    // R8: writes to ID register ignored
    wr('h4, 'hFFFF);
    chk_out("R8 routing after id write");
    rd('h4, 1'b1, q); chk("R8 id still", q, 16'd1);
    check_all_regs("R8 readback");

    // R9: holes
    for (int h = 0; h < 6; h++) begin
      wr(holes[h], 'hFFFF);
      rd(holes[h], 1'b1, q);
      chk("R9 hole read", q, 16'd0);
      chk_out("R9 hole write");
    end
    check_all_regs("R9 readback");

    // R10: one cycle latency
    wr('h80 + 2 * 9, 3); m0[9] = 1; m1[9] = 1;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'('h80 + 2 * 9);
    #1 chk("R10 before edge", bus_rdata, 16'd0);
    @(negedge clk);
    chk("R10 after edge", bus_rdata, 16'd3);
    bus_sel = 1'b0;
    @(negedge clk);
    chk("R10 idle zero", bus_rdata, 16'd0);

    // R12: save, clear, restore
    for (int n = 0; n < NS; n++) rd('h80 + 2 * n, 1'b0, saved[n]);
    for (int n = 0; n < NS; n++) wr('h80 + 2 * n, 0);
    begin
      logic [NS-1:0] s0, s1;
      s0 = m0; s1 = m1; m0 = '0; m1 = '0;
      src_irq = '1;
      chk_out("R12 cleared");
      for (int n = 0; n < NS; n++) wr('h80 + 2 * n, saved[n]);
      m0 = s0; m1 = s1;
    end
    chk_out("R12 restored outputs");
    check_all_regs("R12 restored readback");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule